// File: doc/BRIEF.md
# Presettable Cascadable Four-Bit Counter

This block is a synchronous four-bit counter clocked on the rising edge of one clock. A build-time parameter picks the count range: binary (0 to 15) or decade (0 to 9). A second parameter turns on a direction input so the counter can also count down. Every control takes effect on a clock edge. An active-low clear and an active-low parallel load set the value. Two enables, both active high, must both be high for the counter to step.

A combinational carry output is high when the counter sits at its terminal value and the trailing enable is high. Several instances can be chained into a wider counter:

- Tie the leading enable of every stage to one shared enable.
- Feed each higher stage's trailing enable from the carry of the stage below.

A higher stage then advances only when every stage below it is at its terminal value.

The block has no data stream. All pins are plain control and status wires, and there is no back-pressure.

Top module: `casc_counter`

## Requirements
- R1: With `clr_n` low at a rising edge, the count becomes 0. This holds whatever the load, enable and direction inputs are.
- R2: With `clr_n` high and `load_n` low at a rising edge, the count takes `din`. `din[3]` is the most significant bit. The load works with both enables low, and it overrides counting.
- R3: With `clr_n` and `load_n` high and both `en_p` and `en_t` high, counting up adds one to the count at each rising edge.
- R4: With `clr_n` and `load_n` high and either enable low, the count holds its value.
- R5: Counting up wraps from the last value to 0. The last value is 15 in binary mode and 9 in decade mode.
- R6: In decade mode, a loaded value from 10 to 14 counts up by one per edge. From 15 the count goes to 0.
- R7: With `UPDOWN`=1 and `dir_up`=0, the count goes down by one per edge, and from 0 it wraps to the last value. With `UPDOWN`=0, `dir_up` is ignored and the counter always counts up.
- R8: `rco` is combinational. It equals `en_t` AND (count equals 9 or 15 when counting up, or count equals 0 when counting down).
- R9: Two stages chained as described form a counter of 0 to 255 in binary mode or 00 to 99 in decade mode, counting up or down. The carry ripples within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| dir_up | input | 1 | 1 counts up, 0 counts down (used only when UPDOWN=1) |
| en_p | input | 1 | Leading count enable, active high |
| en_t | input | 1 | Trailing count enable, active high; also gates `rco` |
| din | input | W | Parallel load value, MSB first |
| q | output | W | Current count |
| rco | output | 1 | Terminal-count carry for chaining stages |

## Verification
The bench runs two chained decade stages through more than a full 00 to 99 cycle. This shows both the 9-to-0 wrap of the low digit and whether the carry moves the high digit at exactly the right moment.

A chained binary pair, which can also count down, sweeps 0 to 255 upwards and then downwards. This separates the up and down terminal values and both wrap directions.

Separate patterns cover the remaining cases:
- Holds with only one enable low.
- A load with the enables off.
- A clear asserted together with a load.
- Out-of-range decade loads.
- A counter whose bench drives the load to cycle 5 to 10 while the ignored direction pin toggles.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Action chosen for the count register at the next rising edge, in priority order.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     en_p,
  input  logic     en_t,
  output cnt_act_e act
);
  // Clear beats load; load beats counting and ignores the enables.
  always_comb begin
    if (!clr_n)             act = ACT_CLEAR;
    else if (!load_n)       act = ACT_LOAD;
    else if (en_p && en_t)  act = ACT_STEP;
    else                    act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_step.sv
module cnt_step #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [W-1:0] q,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] LAST = DECADE ? W'(9) : {W{1'b1}};
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  // Counting up wraps at the last value. A value above the decade range
  // runs on to the top code and then rolls over to zero.
  always_comb begin
    if (up) begin
      if (q == LAST || q == TOP) nxt = '0;
      else                       nxt = q + W'(1);
    end else begin
      if (q == '0) nxt = LAST;
      else         nxt = q - W'(1);
    end
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [W-1:0] q,
  input  logic         up,
  input  logic         en_t,
  output logic         rco
);
  localparam logic [W-1:0] LAST = DECADE ? W'(9) : {W{1'b1}};

  logic at_term;

  always_comb begin
    at_term = up ? (q == LAST) : (q == '0);
    rco     = en_t & at_term;
  end
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b0,
  parameter bit UPDOWN = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         dir_up,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rco
);
  cnt_act_e     act;
  logic [W-1:0] nxt;
  logic         up_eff;
  logic [W-1:0] cnt_r;

  // Without the direction option, the pin is ignored and the counter counts up.
  assign up_eff = dir_up | (UPDOWN == 1'b0);

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  cnt_step #(.W(W), .DECADE(DECADE)) u_step (
    .q   (cnt_r),
    .up  (up_eff),
    .nxt (nxt)
  );

  cnt_term #(.W(W), .DECADE(DECADE)) u_term (
    .q    (cnt_r),
    .up   (up_eff),
    .en_t (en_t),
    .rco  (rco)
  );

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_CLEAR: cnt_r <= '0;
      ACT_LOAD:  cnt_r <= din;
      ACT_STEP:  cnt_r <= nxt;
      default:   cnt_r <= cnt_r;
    endcase
  end

  assign q = cnt_r;
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b0,
  parameter bit UPDOWN = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         dir_up,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         rco
);
  localparam logic [W-1:0] LAST = DECADE ? W'(9) : {W{1'b1}};
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  logic seen = 1'b0;
  logic up;

  always_ff @(posedge clk) seen <= seen | ~clr_n;
  assign up = dir_up | (UPDOWN == 1'b0);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!seen)
    !clr_n |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!seen)
    (clr_n && !load_n) |=> (q == $past(din)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!seen)
    (clr_n && load_n && en_p && en_t && up && q != LAST && q != TOP)
      |=> (q == $past(q) + W'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!seen)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  assert_down_wrap_R7: assert property (@(posedge clk) disable iff (!seen)
    (clr_n && load_n && en_p && en_t && !up && q == '0) |=> (q == LAST));

  assert_rco_gate_R8: assert property (@(posedge clk) disable iff (!seen)
    !en_t |-> !rco);
endmodule

bind casc_counter casc_counter_chk #(.W(W), .DECADE(DECADE), .UPDOWN(UPDOWN)) u_chk (.*);

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  logic       clr_n;
  // decade pair u0 (low) / u1 (high)
  logic       d_load_n, d_enp, d_ent;
  logic [3:0] d_lo, d_hi;
  logic [3:0] q0, q1;
  logic       rco0, rco1;
  // binary up/down pair u2 (low) / u3 (high)
  logic       b_load_n, b_enp, b_ent, b_dir;
  logic [3:0] b_lo, b_hi;
  logic [3:0] q2, q3;
  logic       rco2, rco3;
  // binary up-only u4 for the 5..10 loop
  logic       c_load_n, c_dir;
  logic [3:0] q4;
  logic       rco4;
  // decade up/down u5
  logic       e_load_n, e_en, e_dir;
  logic [3:0] e_din, q5;
  logic       rco5;

  casc_counter #(.W(4), .DECADE(1'b1), .UPDOWN(1'b0)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(d_load_n), .dir_up(1'b1),
    .en_p(d_enp), .en_t(d_ent), .din(d_lo), .q(q0), .rco(rco0));
  casc_counter #(.W(4), .DECADE(1'b1), .UPDOWN(1'b0)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(d_load_n), .dir_up(1'b1),
    .en_p(d_enp), .en_t(rco0), .din(d_hi), .q(q1), .rco(rco1));
  casc_counter #(.W(4), .DECADE(1'b0), .UPDOWN(1'b1)) u2 (
    .clk(clk), .clr_n(clr_n), .load_n(b_load_n), .dir_up(b_dir),
    .en_p(b_enp), .en_t(b_ent), .din(b_lo), .q(q2), .rco(rco2));
  casc_counter #(.W(4), .DECADE(1'b0), .UPDOWN(1'b1)) u3 (
    .clk(clk), .clr_n(clr_n), .load_n(b_load_n), .dir_up(b_dir),
    .en_p(b_enp), .en_t(rco2), .din(b_hi), .q(q3), .rco(rco3));
  casc_counter #(.W(4), .DECADE(1'b0), .UPDOWN(1'b0)) u4 (
    .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .dir_up(c_dir),
    .en_p(1'b1), .en_t(1'b1), .din(4'd5), .q(q4), .rco(rco4));
  casc_counter #(.W(4), .DECADE(1'b1), .UPDOWN(1'b1)) u5 (
    .clk(clk), .clr_n(clr_n), .load_n(e_load_n), .dir_up(e_dir),
    .en_p(e_en), .en_t(e_en), .din(e_din), .q(q5), .rco(rco5));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e;
    int s;
    clr_n = 1'b0;
    d_load_n = 1'b0; d_enp = 1'b1; d_ent = 1'b1; d_lo = 4'd7; d_hi = 4'd3;
    b_load_n = 1'b0; b_enp = 1'b1; b_ent = 1'b1; b_dir = 1'b1; b_lo = 4'd9; b_hi = 4'd9;
    c_load_n = 1'b0; c_dir = 1'b1;
    e_load_n = 1'b0; e_en = 1'b1; e_dir = 1'b1; e_din = 4'd4;
    tick(); tick();
    // R1: clear wins over load and enables
    chk("R1 u0", q0, 0); chk("R1 u1", q1, 0); chk("R1 u2", q2, 0);
    chk("R1 u3", q3, 0); chk("R1 u4", q4, 0); chk("R1 u5", q5, 0);

    clr_n = 1'b1;
    d_load_n = 1'b1; b_load_n = 1'b1; b_enp = 1'b0; c_load_n = 1'b1; e_load_n = 1'b1; e_en = 1'b0;
    // R3 R5 R8 R9: decade pair through 00..99 and past the wrap
    for (int i = 1; i <= 120; i++) begin
      tick();
      e = i % 100;
      chk("R9 decade hi", q1, e / 10);
      chk("R5 decade lo", q0, e % 10);
      chk("R8 decade rco", rco0, (e % 10 == 9) ? 1 : 0);
    end
    chk("R4 binary held", {q3, q2}, 0);
    // R4: either enable low holds; R8: rco follows en_t
    d_enp = 1'b0;
    tick(); tick();
    chk("R4 enp low", {q1, q0}, 8'h20);
    d_enp = 1'b1; d_ent = 1'b0;
    tick(); tick();
    chk("R4 ent low", {q1, q0}, 8'h20);
    d_lo = 4'd9; d_load_n = 1'b0; d_enp = 1'b0;
    tick();
    // R2: load with both enables low
    chk("R2 load lo", q0, 9);
    chk("R2 load hi", q1, 3);
    chk("R8 rco gated", rco0, 0);
    d_ent = 1'b1;
    #1;
    chk("R8 rco at 9", rco0, 1);
    // R6: out-of-range decade value
    d_lo = 4'd12;
    tick();
    d_load_n = 1'b1; d_enp = 1'b1;
    chk("R2 load 12", q0, 12);
    tick(); chk("R6 13", q0, 13);
    tick(); chk("R6 14", q0, 14);
    tick(); chk("R6 15", q0, 15);
    chk("R6 hi stays", q1, 3);
    tick(); chk("R6 wrap", q0, 0);
    chk("R6 no carry", q1, 3);

    // R3 R5 R9: binary pair up through 256 and beyond
    d_enp = 1'b0;
    b_enp = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      tick();
      chk("R9 binary up", {q3, q2}, i % 256);
      chk("R8 up rco", rco2, ((i % 16) == 15) ? 1 : 0);
    end
    // R7: count down across zero
    b_dir = 1'b0;
    #1;
    chk("R8 down rco", rco2, 0);
    s = 300 % 256;
    for (int i = 1; i <= 300; i++) begin
      tick();
      e = ((s - i) % 256 + 256) % 256;
      chk("R7 binary down", {q3, q2}, e);
      chk("R8 down rco", rco2, ((e % 16) == 0) ? 1 : 0);
    end
    // R2: 8-bit load, MSB ordering
    b_lo = 4'b0101; b_hi = 4'b1010; b_load_n = 1'b0; b_enp = 1'b0;
    tick();
    b_load_n = 1'b1;
    chk("R2 binary load", {q3, q2}, 8'hA5);

    // R7: decade down wraps to 9
    e_din = 4'd0; e_load_n = 1'b0;
    tick();
    e_load_n = 1'b1; e_en = 1'b1; e_dir = 1'b0;
    tick(); chk("R7 decade down wrap", q5, 9);
    tick(); chk("R7 decade down", q5, 8);
    e_dir = 1'b1;
    tick(); chk("R5 decade up", q5, 9);
    tick(); chk("R5 decade wrap", q5, 0);

    // R2 R7: load-driven 5..10 loop; direction pin toggled and ignored
    tick();
    e = q4;
    for (int i = 0; i < 40; i++) begin
      c_load_n = (q4 == 4'd10) ? 1'b0 : 1'b1;
      c_dir = ~c_dir;
      tick();
      e = (e == 10) ? 5 : e + 1;
      chk("R2 loop", q4, e);
    end
    finish_run();
  end
endmodule